// File: doc/BRIEF.md
# Encoder Input Conditioning Stage

This block prepares the four raw signals of an incremental encoder (phase A, phase B, index and home) before they reach a quadrature decoder. Each raw pin first crosses into the system clock domain through a short flop chain. A per-pin inversion control then sets its active sense, and an exchange control can swap the two phase signals so that the decoder sees the opposite rotation sense. The conditioned levels are brought out as status bits. A registered output copy goes on to the decoder, either directly or through a glitch filter.

The filter samples on a strobe from a free-running divider. A 3-bit code sets the strobe rate to the system clock divided by 2 to the power of the code. A filtered output takes a new level only after the conditioned input has shown that level on a set number of consecutive strobes. The divider restarts whenever the code changes. All controls are plain input levels that the surrounding register logic drives.

Top module: `enc_input_cond`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every conditioned output (`out_a`, `out_b`, `out_idx`, `out_home`) is 0 after that edge, and the synchronizer and filter state clears to 0.
- R2: Each raw pin passes through a two-flop synchronizer. A level applied before clock edge k shows on the matching status bit after edge k+1 and not before.
- R3: Each pin has its own inversion control. A value of 1 inverts that pin's level in both status and output, and 0 passes it unchanged.
- R4: When `swap_ab` is 1, the phase signals are exchanged after inversion: `stat_a` carries the synchronized `pin_b` XOR `inv_b`, and `stat_b` carries the synchronized `pin_a` XOR `inv_a`. The same exchange reaches `out_a` and `out_b`.
- R5: `stat_idx` and `stat_home` reflect inversion only. All four status bits are combinational from the synchronizer output and are never filtered.
- R6: With `filt_en` at 0 the filter is bypassed: each output equals its status bit as it stood one clock earlier.
- R7: With `filt_en` at 1, an output takes a new level only on the third consecutive sample strobe at which its conditioned input differs from the output. A strobe that sees agreement clears the run, so shorter pulses are rejected, and between strobes the outputs hold.
- R8: The sample strobe is a one-cycle pulse with period 2^`div_code` clocks (code 0 gives a strobe every cycle, code 7 one in 128). Counted from a restart, the first strobe falls on cycle 2^`div_code` − 1.
- R9: A change of `div_code` restarts the divider. The strobe pattern is then counted afresh from the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 1 | Raw phase A pin, asynchronous |
| pin_b | input | 1 | Raw phase B pin, asynchronous |
| pin_idx | input | 1 | Raw index pin, asynchronous |
| pin_home | input | 1 | Raw home pin, asynchronous |
| inv_a | input | 1 | Invert phase A when 1 |
| inv_b | input | 1 | Invert phase B when 1 |
| inv_idx | input | 1 | Invert index when 1 |
| inv_home | input | 1 | Invert home when 1 |
| swap_ab | input | 1 | Exchange phase A and B after inversion |
| filt_en | input | 1 | Enable glitch filter; 0 bypasses it |
| div_code | input | 3 | Strobe divide code, ratio 2^code |
| out_a | output | 1 | Conditioned phase A to decoder |
| out_b | output | 1 | Conditioned phase B to decoder |
| out_idx | output | 1 | Conditioned index to decoder |
| out_home | output | 1 | Conditioned home to decoder |
| stat_a | output | 1 | Phase A level after inversion and swap |
| stat_b | output | 1 | Phase B level after inversion and swap |
| stat_idx | output | 1 | Index level after inversion |
| stat_home | output | 1 | Home level after inversion |

## Verification
The hardest cases to reach are a filter run cut short by one strobe of agreement, and a divide code change that lands between two strobes. Neither shows at the ports until several strobes later. The stimulus applies pulses of one, two, three and four strobe periods at several divide codes, and it changes the code while a run is partly counted. A behavioural model in the bench tracks the strobe phase with plain integers from the restart point, so the exact cycle of every accepted or rejected edge is predicted and compared each clock.

// File: rtl/enc_cond_pkg.sv
// Shared definitions for the encoder input conditioning stage.
// Assumes the four signals are always packed in the order A, B, index, home.
package enc_cond_pkg;

    localparam int NUM_PINS = 4;

    // Bit positions inside a packed pin vector
    typedef enum int {
        PIN_A    = 0,
        PIN_B    = 1,
        PIN_IDX  = 2,
        PIN_HOME = 3
    } pin_pos_e;

    typedef logic [NUM_PINS-1:0] pin_vec_t;

endpackage

// File: rtl/enc_sync_chain.sv
// Multi-bit synchronizer: each bit passes through STAGES flops in series.
// Assumes the bits are independent, so no coherence between them is needed.
module enc_sync_chain #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_async;
                end
            end else begin : g_next
                // Shift one stage further along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/enc_pol_swap.sv
// Applies per-pin inversion and then optionally exchanges the A and B phases.
// Purely combinational; assumes a synchronized input vector.
module enc_pol_swap
    import enc_cond_pkg::*;
(
    input  pin_vec_t sync_in,
    input  pin_vec_t invert,
    input  logic     swap_ab,
    output pin_vec_t cond_out
);

    pin_vec_t polar;

    // Invert each pin whose control bit is set
    always_comb polar = sync_in ^ invert;

    // Exchange phases after inversion; index and home go straight through
    always_comb begin
        cond_out           = polar;
        cond_out[PIN_A]    = swap_ab ? polar[PIN_B] : polar[PIN_A];
        cond_out[PIN_B]    = swap_ab ? polar[PIN_A] : polar[PIN_B];
    end

endmodule

// File: rtl/enc_sample_div.sv
// Free-running power-of-two divider producing a one-cycle sample strobe.
// The strobe fires when the low CODE bits of the counter are all ones.
// Assumes the counter width covers the largest ratio, so wrap keeps the period.
// Any change of the code restarts the count from zero.
module enc_sample_div #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    output logic              tick
);

    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  mask;

    // Mask of the counter bits that must be all ones for a strobe
    always_comb mask = CNT_W'((1 << code_q) - 1);

    // Strobe decode from the current count and the registered code
    always_comb tick = ((cnt_q & mask) == mask);

    // Advance the counter, restarting it when the code changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else if (div_code != code_q) begin
            cnt_q  <= '0;
            code_q <= div_code;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/enc_glitch_filt.sv
// Single-bit glitch filter. The output adopts a new level once the input has
// differed from it on HOLD consecutive strobes. Disabled, it is a plain register.
// Assumes the input is already synchronous to clk.
module enc_glitch_filt #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic d,
    output logic q
);

    localparam int RUN_W = $clog2(HOLD + 1);

    logic [RUN_W-1:0] run_q;

    // Count disagreeing strobes and commit the new level after HOLD of them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= 1'b0;
            run_q <= '0;
        end else if (!en) begin
            q     <= d;
            run_q <= '0;
        end else if (tick) begin
            if (d != q) begin
                if (run_q == RUN_W'(HOLD - 1)) begin
                    q     <= d;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/enc_input_cond.sv
// Encoder input conditioning top: synchronizer, inversion and swap, then a
// glitch filter per pin driven by a shared sample-strobe divider.
// Status bits are the unfiltered conditioned levels. Outputs are registered.
// Assumes the controls are static or change synchronously to clk.
module enc_input_cond
    import enc_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 3,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              pin_idx,
    input  logic              pin_home,
    input  logic              inv_a,
    input  logic              inv_b,
    input  logic              inv_idx,
    input  logic              inv_home,
    input  logic              swap_ab,
    input  logic              filt_en,
    input  logic [CODE_W-1:0] div_code,
    output logic              out_a,
    output logic              out_b,
    output logic              out_idx,
    output logic              out_home,
    output logic              stat_a,
    output logic              stat_b,
    output logic              stat_idx,
    output logic              stat_home
);

    pin_vec_t raw_v;
    pin_vec_t inv_v;
    pin_vec_t sync_v;
    pin_vec_t stat_v;
    pin_vec_t out_v;
    logic     smp_tick;

    // Pack the scalar pins and controls into vectors
    always_comb begin
        raw_v[PIN_A]    = pin_a;
        raw_v[PIN_B]    = pin_b;
        raw_v[PIN_IDX]  = pin_idx;
        raw_v[PIN_HOME] = pin_home;
        inv_v[PIN_A]    = inv_a;
        inv_v[PIN_B]    = inv_b;
        inv_v[PIN_IDX]  = inv_idx;
        inv_v[PIN_HOME] = inv_home;
    end

    enc_sync_chain #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_v),
        .q_sync  (sync_v)
    );

    enc_pol_swap u_polsw (
        .sync_in  (sync_v),
        .invert   (inv_v),
        .swap_ab  (swap_ab),
        .cond_out (stat_v)
    );

    enc_sample_div #(
        .CODE_W (CODE_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .tick     (smp_tick)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_filt
            enc_glitch_filt #(
                .HOLD (HOLD_TICKS)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (filt_en),
                .tick  (smp_tick),
                .d     (stat_v[p]),
                .q     (out_v[p])
            );
        end
    endgenerate

    // Unpack the vectors onto the scalar ports
    always_comb begin
        stat_a    = stat_v[PIN_A];
        stat_b    = stat_v[PIN_B];
        stat_idx  = stat_v[PIN_IDX];
        stat_home = stat_v[PIN_HOME];
        out_a     = out_v[PIN_A];
        out_b     = out_v[PIN_B];
        out_idx   = out_v[PIN_IDX];
        out_home  = out_v[PIN_HOME];
    end

endmodule

// File: rtl/enc_input_cond_chk.sv
// Property checker for enc_input_cond, attached by bind below.
// Assumes the reset is held low for at least one clock at start.
module enc_input_cond_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              filt_en,
    input logic [CODE_W-1:0] div_code,
    input logic              smp_tick,
    input logic [3:0]        stat_v,
    input logic [3:0]        out_v
);

    logic was_rst_q;

    // Remember whether the previous edge applied reset
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    // Check the output state away from the edge after a reset cycle
    always @(negedge clk) begin
        if (was_rst_q) begin
            // R1
            reset_clear_chk: assert (out_v == 4'b0000)
                else $error("outputs not cleared by reset");
        end
    end

    // R6
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> (out_v == $past(stat_v)))
        else $error("bypass output does not follow status");

    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !smp_tick) |=> $stable(out_v))
        else $error("filtered output moved without a strobe");

    // R8
    code_zero_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code == '0 && $stable(div_code)) |-> smp_tick)
        else $error("code 0 must strobe every cycle");

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_tick && div_code != '0 && $stable(div_code)) |=> !smp_tick)
        else $error("strobe wider than one cycle");

endmodule

bind enc_input_cond enc_input_cond_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .filt_en  (filt_en),
    .div_code (div_code),
    .smp_tick (smp_tick),
    .stat_v   (stat_v),
    .out_v    (out_v)
);

// File: tb/sim_enc_input_cond.sv
// Self-checking bench with a behavioural per-cycle reference model.
module sim_enc_input_cond;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin_a, pin_b, pin_idx, pin_home;
    logic       inv_a, inv_b, inv_idx, inv_home;
    logic       swap_ab, filt_en;
    logic [2:0] div_code;
    logic       out_a, out_b, out_idx, out_home;
    logic       stat_a, stat_b, stat_idx, stat_home;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 0;

    always #2.5 clk = ~clk;

    enc_input_cond u0 (
        .clk(clk), .rst_n(rst_n),
        .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx), .pin_home(pin_home),
        .inv_a(inv_a), .inv_b(inv_b), .inv_idx(inv_idx), .inv_home(inv_home),
        .swap_ab(swap_ab), .filt_en(filt_en), .div_code(div_code),
        .out_a(out_a), .out_b(out_b), .out_idx(out_idx), .out_home(out_home),
        .stat_a(stat_a), .stat_b(stat_b), .stat_idx(stat_idx), .stat_home(stat_home)
    );

    // Reference model state
    bit m_s1 [4];
    bit m_s2 [4];
    bit m_f  [4];
    int m_run[4];
    int m_cnt  = 0;
    int m_code = 0;

    function automatic bit pin_of(int i);
        case (i)
            0: return pin_a;
            1: return pin_b;
            2: return pin_idx;
            default: return pin_home;
        endcase
    endfunction

    function automatic bit inv_of(int i);
        case (i)
            0: return inv_a;
            1: return inv_b;
            2: return inv_idx;
            default: return inv_home;
        endcase
    endfunction

    // Expected status: invert the physical pin, then exchange the phases
    function automatic bit exp_stat(int i);
        int src;
        src = i;
        if (swap_ab && i == 0) src = 1;
        if (swap_ab && i == 1) src = 0;
        return m_s2[src] ^ inv_of(src);
    endfunction

    always @(posedge clk) begin
        bit cond [4];
        bit tick;
        int per;
        for (int i = 0; i < 4; i++) cond[i] = exp_stat(i);
        per  = 1 << m_code;
        tick = ((m_cnt % per) == per - 1);
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
            end
            m_cnt = 0; m_code = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (!filt_en) begin
                    m_f[i] = cond[i]; m_run[i] = 0;
                end else if (tick) begin
                    if (cond[i] != m_f[i]) begin
                        m_run[i]++;
                        if (m_run[i] == 3) begin m_f[i] = cond[i]; m_run[i] = 0; end
                    end else m_run[i] = 0;
                end
            end
            if (int'(div_code) != m_code) begin m_cnt = 0; m_code = int'(div_code); end
            else m_cnt = (m_cnt + 1) % 128;
            for (int i = 0; i < 4; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = pin_of(i); end
        end
    end

    task automatic check(input bit act, input bit exp, input string tag, input string sig);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s actual=%0b expected=%0b at %0t", tag, phase, sig, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n === 1'b1 || phase == "R1") begin
            string otag;
            otag = filt_en ? "R7" : "R6";
            check(stat_a,    exp_stat(0), "R5", "stat_a");
            check(stat_b,    exp_stat(1), "R5", "stat_b");
            check(stat_idx,  exp_stat(2), "R5", "stat_idx");
            check(stat_home, exp_stat(3), "R5", "stat_home");
            check(out_a,    m_f[0], otag, "out_a");
            check(out_b,    m_f[1], otag, "out_b");
            check(out_idx,  m_f[2], otag, "out_idx");
            check(out_home, m_f[3], otag, "out_home");
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pins(input logic [3:0] v);
        {pin_home, pin_idx, pin_b, pin_a} = v;
    endtask

    initial begin
        rst_n = 0; set_pins(4'b0000);
        {inv_home, inv_idx, inv_b, inv_a} = 4'b0000;
        swap_ab = 0; filt_en = 0; div_code = 3'd0;
        step(4);
        // R1: reset state of outputs
        @(negedge clk);
        check(out_a | out_b | out_idx | out_home, 1'b0, "R1", "outs");
        step(0);
        rst_n = 1;
        step(2);

        // R2: synchronizer latency of two edges
        phase = "R2";
        set_pins(4'b0001);
        @(posedge clk); @(negedge clk);
        check(stat_a, 1'b0, "R2", "stat_a early");
        @(posedge clk); @(negedge clk);
        check(stat_a, 1'b1, "R2", "stat_a late");
        step(0);
        for (int i = 0; i < 16; i++) begin set_pins(4'(i)); step(3); end

        // R3: per-pin inversion
        phase = "R3";
        for (int k = 0; k < 16; k++) begin
            {inv_home, inv_idx, inv_b, inv_a} = 4'(k);
            set_pins(4'(k * 7));
            step(4);
        end

        // R4: phase exchange
        phase = "R4";
        swap_ab = 1;
        set_pins(4'b0010); step(4);
        set_pins(4'b0001); step(4);
        {inv_home, inv_idx, inv_b, inv_a} = 4'b0001;
        set_pins(4'b0011); step(4);
        swap_ab = 0; step(3);
        {inv_home, inv_idx, inv_b, inv_a} = 4'b0000;

        // R6: bypass with a random pin stream
        phase = "R6";
        for (int i = 0; i < 200; i++) begin
            set_pins(4'($urandom));
            swap_ab = 1'($urandom);
            step(1);
        end
        swap_ab = 0; set_pins(4'b0000); step(4);

        // R7: filter at code 0, pulses of 1..4 strobes
        phase = "R7";
        filt_en = 1;
        for (int w = 1; w <= 4; w++) begin
            set_pins(4'b1111); step(w);
            set_pins(4'b0000); step(8);
        end
        set_pins(4'b0101); step(10);
        set_pins(4'b0000); step(10);

        // R8: every divide code with pulses around the accept width
        phase = "R8";
        for (int c = 0; c < 8; c++) begin
            div_code = 3'(c);
            for (int w = 1; w <= 4; w++) begin
                set_pins(4'b1010); step(w * (1 << c));
                set_pins(4'b0000); step(4 * (1 << c));
            end
        end

        // R9: code changes while a run is partly counted
        phase = "R9";
        for (int r = 0; r < 40; r++) begin
            div_code = 3'($urandom_range(0, 4));
            set_pins(4'($urandom));
            step($urandom_range(1, 20));
        end
        filt_en = 0; step(5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog (%s) actual=running expected=finished", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule